// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the control-flow outcome of one jump-class instruction per clock. It receives the 4-bit jump code, a bit that picks the second operand (register or immediate), a bit that narrows the comparison to the low half of the operands, the two register operands, the 32-bit immediate, a signed 16-bit displacement and the current program counter. One cycle later it presents whether the branch is taken, the program counter to fetch next, and three mutually exclusive flags: call, exit and illegal encoding.

The program counter counts 8-byte instruction slots. The sequential successor is therefore pc + 1, and a taken branch lands on pc + 1 + displacement. One shared comparator produces equality, unsigned-less-than, signed-less-than and a nonzero bit-test result. Every conditional code is a selection over those four results. The comparator works either on the full operand width or on the low half, depending on the narrow bit.

The unit only resolves the branch. Performing a call, saving registers and fetching instructions are handled by the surrounding pipeline.

Top module: `jump_resolve_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output (`taken`, `next_pc`, `is_call`, `is_exit`, `illegal`) becomes zero at that edge. All outputs are registered and reflect the inputs sampled at the previous rising edge.
- R2: Code 0x1 is taken when the two compared operands are equal. Code 0x5 is taken when they differ.
- R3: These codes compare as unsigned numbers: 0x2 is taken when a > b, 0x3 when a >= b, 0xa when a < b, and 0xb when a <= b.
- R4: These codes compare as two's-complement numbers: 0x6 is taken when a > b, 0x7 when a >= b, 0xc when a < b, and 0xd when a <= b.
- R5: Code 0x4 is taken when the bitwise AND of the two compared operands is nonzero.
- R6: With `narrow` = 1, only bits [31:0] of both operands take part in every comparison, with bit 31 as the sign. The upper 32 bits have no effect on the result.
- R7: With `use_reg` = 0, the second operand is `imm` sign-extended from bit 31 to 64 bits, instead of `opb`.
- R8: A taken branch sets `next_pc` = pc + 1 + sign-extended `offset`, wrapping modulo 2^32.
- R9: Whenever `taken` is 0, `next_pc` = pc + 1, wrapping modulo 2^32.
- R10: Code 0x0 is always taken when `narrow` = 0. Codes 0x0 and 0x9 with `narrow` = 1, and codes 0xe and 0xf in either width, raise `illegal` and are not taken.
- R11: Code 0x8 raises `is_call` in either width. Code 0x9 with `narrow` = 0 raises `is_exit`. Neither of these codes is taken.
- R12: At most one of `taken`, `is_call`, `is_exit` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| jcode | input | 4 | Jump operation code |
| use_reg | input | 1 | 1: second operand is `opb`; 0: sign-extended `imm` |
| narrow | input | 1 | 1: compare low 32 bits only; 0: full 64-bit compare |
| opa | input | 64 | First (destination-register) operand |
| opb | input | 64 | Second (source-register) operand |
| imm | input | 32 | Immediate operand |
| offset | input | 16 | Signed branch displacement in instruction slots |
| pc | input | 32 | Current program counter in instruction slots |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Program counter to fetch next |
| is_call | output | 1 | Call code decoded |
| is_exit | output | 1 | Exit code decoded |
| illegal | output | 1 | Illegal code/width combination |

## Verification
The bench builds the unit with its default parameters: 64-bit operands, a 32-bit immediate, a 16-bit displacement and a 32-bit program counter. With these values the narrow mode is exactly the low 32 bits. This makes it possible to choose operands whose upper halves disagree with their lower halves, so a compare that wrongly uses the upper bits gives a visibly different outcome. Because the program counter is 32 bits, its wrap from 0xFFFFFFFF to zero and a negative displacement are both reachable within a few vectors.

// File: rtl/jru_pkg.sv
package jru_pkg;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_TEST   = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_CALL   = 4'h8,
        JC_RET    = 4'h9,
        JC_ULT    = 4'ha,
        JC_ULE    = 4'hb,
        JC_SLT    = 4'hc,
        JC_SLE    = 4'hd
    } jcode_e;

    localparam logic [3:0] JC_LAST = 4'hd;

    // Relation results from the shared comparator
    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic any;
    } rel_t;

    // Decoded instruction classification
    typedef struct packed {
        logic legal;
        logic branch;
        logic call;
        logic ret;
    } kind_t;

    // Select the condition outcome from the relation bundle
    function automatic logic cond_met(input logic [3:0] code, input rel_t r);
        logic hit;
        case (jcode_e'(code))
            JC_ALWAYS: hit = 1'b1;
            JC_EQ:     hit = r.eq;
            JC_NE:     hit = !r.eq;
            JC_UGT:    hit = !r.ult && !r.eq;
            JC_UGE:    hit = !r.ult;
            JC_ULT:    hit = r.ult;
            JC_ULE:    hit = r.ult || r.eq;
            JC_SGT:    hit = !r.slt && !r.eq;
            JC_SGE:    hit = !r.slt;
            JC_SLT:    hit = r.slt;
            JC_SLE:    hit = r.slt || r.eq;
            JC_TEST:   hit = r.any;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/jru_decode.sv
module jru_decode
    import jru_pkg::*;
(
    input  logic [3:0] code,
    input  logic       narrow,
    output kind_t      kind
);

    logic in_range;
    logic wide_only;

    always_comb begin
        in_range  = (code <= JC_LAST);
        wide_only = (code == JC_ALWAYS) || (code == JC_RET);
        kind.legal  = in_range && !(narrow && wide_only);
        kind.call   = kind.legal && (code == JC_CALL);
        kind.ret    = kind.legal && (code == JC_RET);
        kind.branch = kind.legal && !kind.call && !kind.ret;
    end

endmodule

// File: rtl/jru_compare.sv
module jru_compare
    import jru_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_reg,
    input  logic             narrow,
    output rel_t             rel
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] src;
    logic [XLEN-1:0] a_u, b_u, a_s, b_s;

    generate
        if (IMM_W < XLEN) begin : g_imm_ext
            assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_imm_trunc
            assign imm_x = imm[XLEN-1:0];
        end
    endgenerate

    assign src = use_reg ? opb : imm_x;

    // Zero-extended view for unsigned/equality/test, sign-extended for signed
    always_comb begin
        if (narrow) begin
            a_u = {{HALF{1'b0}}, opa[HALF-1:0]};
            b_u = {{HALF{1'b0}}, src[HALF-1:0]};
            a_s = {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
            b_s = {{HALF{src[HALF-1]}}, src[HALF-1:0]};
        end else begin
            a_u = opa;
            b_u = src;
            a_s = opa;
            b_s = src;
        end
        rel.eq  = (a_u == b_u);
        rel.ult = (a_u < b_u);
        rel.slt = ($signed(a_s) < $signed(b_s));
        rel.any = |(a_u & b_u);
    end

endmodule

// File: rtl/jru_target.sv
module jru_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  jump_pc
);

    logic [PC_W-1:0] disp;

    generate
        if (OFF_W < PC_W) begin : g_off_ext
            assign disp = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_off_trunc
            assign disp = offset[PC_W-1:0];
        end
    endgenerate

    assign seq_pc  = pc + PC_W'(1);
    assign jump_pc = seq_pc + disp;

endmodule

// File: rtl/jump_resolve_unit.sv
module jump_resolve_unit
    import jru_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32,
    parameter int OFF_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       jcode,
    input  logic             use_reg,
    input  logic             narrow,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [IMM_W-1:0] imm,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  pc,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic             is_call,
    output logic             is_exit,
    output logic             illegal
);

    kind_t           kind;
    rel_t            rel;
    logic [PC_W-1:0] seq_pc, jump_pc;
    logic            take_d;

    jru_decode u_decode (
        .code   (jcode),
        .narrow (narrow),
        .kind   (kind)
    );

    jru_compare #(.XLEN(XLEN), .IMM_W(IMM_W)) u_compare (
        .opa     (opa),
        .opb     (opb),
        .imm     (imm),
        .use_reg (use_reg),
        .narrow  (narrow),
        .rel     (rel)
    );

    jru_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc      (pc),
        .offset  (offset),
        .seq_pc  (seq_pc),
        .jump_pc (jump_pc)
    );

    assign take_d = kind.branch && cond_met(jcode, rel);

    always_ff @(posedge clk) begin
        if (rst) begin
            taken   <= 1'b0;
            next_pc <= '0;
            is_call <= 1'b0;
            is_exit <= 1'b0;
            illegal <= 1'b0;
        end else begin
            taken   <= take_d;
            next_pc <= take_d ? jump_pc : seq_pc;
            is_call <= kind.call;
            is_exit <= kind.ret;
            illegal <= !kind.legal;
        end
    end

    // Assertion support: high once outputs reflect post-reset inputs
    logic            primed_q;
    logic [PC_W-1:0] chk_disp;

    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end

    assign chk_disp = PC_W'($signed(offset));

    p_one_outcome_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({taken, is_call, is_exit, illegal}));

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!taken && next_pc == $past(pc) + PC_W'(1)));

    p_fallthru_r9: assert property (@(posedge clk) disable iff (rst)
        (primed_q && !taken) |-> next_pc == $past(pc) + PC_W'(1));

    p_target_r8: assert property (@(posedge clk) disable iff (rst)
        (primed_q && taken) |-> next_pc == $past(pc) + PC_W'(1) + $past(chk_disp));

    p_always_wide_r10: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(jcode) == 4'h0 && !$past(narrow)) |-> taken);

    p_call_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(jcode) == 4'h8) |-> (is_call && !taken));

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!taken && next_pc == '0 && !is_call && !is_exit && !illegal));

endmodule

// File: tb/jump_resolve_unit_test.sv
module jump_resolve_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  jcode;
    logic        use_reg, narrow;
    logic [63:0] opa, opb;
    logic [31:0] imm;
    logic [15:0] offset;
    logic [31:0] pc;
    logic        taken, is_call, is_exit, illegal;
    logic [31:0] next_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    jump_resolve_unit uut (
        .clk(clk), .rst(rst), .jcode(jcode), .use_reg(use_reg), .narrow(narrow),
        .opa(opa), .opb(opb), .imm(imm), .offset(offset), .pc(pc),
        .taken(taken), .next_pc(next_pc), .is_call(is_call),
        .is_exit(is_exit), .illegal(illegal)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic        ureg;
        logic        nar;
        logic [63:0] a;
        logic [63:0] b;
        logic [31:0] im;
        logic [15:0] off;
        logic [31:0] p;
        logic        tk;
        logic [31:0] npc;
        logic [2:0]  fl;   // {illegal, call, exit}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    localparam vec_t VEC [NV] = '{
        // R2 equality
        '{4'h1,1'b1,1'b0,64'd5,64'd5,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd2},
        '{4'h5,1'b1,1'b0,64'd5,64'd5,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd2},
        // R3 unsigned
        '{4'h2,1'b1,1'b0,ONES,64'd1,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd3},
        '{4'ha,1'b1,1'b0,64'd1,64'd2,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd3},
        '{4'hb,1'b1,1'b0,64'd2,64'd2,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd3},
        '{4'h3,1'b1,1'b0,64'd1,64'd2,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd3},
        // R4 signed
        '{4'h6,1'b1,1'b0,ONES,64'd1,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd4},
        '{4'hc,1'b1,1'b0,ONES,64'd1,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd4},
        '{4'h7,1'b1,1'b0,-64'sd5,-64'sd5,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd4},
        '{4'hd,1'b1,1'b0,64'd3,-64'sd2,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd4},
        // R5 bit test
        '{4'h4,1'b1,1'b0,64'hF0,64'h0F,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd5},
        '{4'h4,1'b1,1'b0,64'h8000_0000_0000_0000,64'h8000_0000_0000_0000,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd5},
        // R6 narrow width
        '{4'h1,1'b1,1'b1,64'h1_0000_0007,64'h2_0000_0007,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd6},
        '{4'h1,1'b1,1'b0,64'h1_0000_0007,64'h2_0000_0007,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd6},
        '{4'h4,1'b1,1'b1,64'hFFFF_FFFF_0000_0000,64'hFFFF_FFFF_0000_0000,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd6},
        '{4'h6,1'b1,1'b1,64'h0000_0000_8000_0000,64'd1,32'd0,16'd5,32'd100,1'b0,32'd101,3'b000,8'd6},
        // R7 immediate sign extension
        '{4'h1,1'b0,1'b0,ONES,64'd0,32'hFFFF_FFFF,16'd5,32'd100,1'b1,32'd106,3'b000,8'd7},
        '{4'h2,1'b0,1'b0,64'h0000_0000_FFFF_FFFF,64'd0,32'hFFFF_FFFF,16'd5,32'd100,1'b0,32'd101,3'b000,8'd7},
        // R8 target arithmetic
        '{4'h0,1'b1,1'b0,64'd0,64'd0,32'd0,16'hFFFE,32'd100,1'b1,32'd99,3'b000,8'd8},
        '{4'h0,1'b1,1'b0,64'd0,64'd0,32'd0,16'd0,32'hFFFF_FFFF,1'b1,32'd0,3'b000,8'd8},
        // R10 illegal combinations
        '{4'h0,1'b1,1'b1,64'd0,64'd0,32'd0,16'd5,32'd100,1'b0,32'd101,3'b100,8'd10},
        '{4'h9,1'b1,1'b1,64'd0,64'd0,32'd0,16'd5,32'd100,1'b0,32'd101,3'b100,8'd10},
        '{4'he,1'b1,1'b0,64'd0,64'd0,32'd0,16'd5,32'd100,1'b0,32'd101,3'b100,8'd10},
        '{4'hf,1'b1,1'b1,64'd0,64'd0,32'd0,16'd5,32'd100,1'b0,32'd101,3'b100,8'd10},
        '{4'h0,1'b1,1'b0,64'd0,64'd0,32'd0,16'd5,32'd100,1'b1,32'd106,3'b000,8'd10},
        // R11 call / exit flags
        '{4'h8,1'b1,1'b0,64'd1,64'd1,32'd0,16'd5,32'd100,1'b0,32'd101,3'b010,8'd11},
        '{4'h8,1'b1,1'b1,64'd1,64'd1,32'd0,16'd5,32'd100,1'b0,32'd101,3'b010,8'd11},
        '{4'h9,1'b1,1'b0,64'd1,64'd1,32'd0,16'd5,32'd100,1'b0,32'd101,3'b001,8'd11}
    };

    task automatic drive(input vec_t v);
        jcode = v.code; use_reg = v.ureg; narrow = v.nar;
        opa = v.a; opb = v.b; imm = v.im; offset = v.off; pc = v.p;
    endtask

    task automatic expect_out(input string tag, input logic tk, input logic [31:0] npc,
                              input logic [2:0] fl);
        checks++;
        if (taken !== tk || next_pc !== npc || {illegal, is_call, is_exit} !== fl) begin
            errors++;
            $display("FAIL %s: taken=%0b next_pc=%0d flags=%03b expected taken=%0b next_pc=%0d flags=%03b",
                     tag, taken, next_pc, {illegal, is_call, is_exit}, tk, npc, fl);
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(VEC[0]);
        @(negedge clk);
        @(negedge clk);
        expect_out("R1 reset", 1'b0, 32'd0, 3'b000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(VEC[i]);
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            expect_out(tag, VEC[i].tk, VEC[i].npc, VEC[i].fl);
            if (VEC[i].tk) begin
                checks++;
                if ({is_call, is_exit, illegal} !== 3'b000) begin
                    errors++;
                    $display("FAIL R12 vec%0d: flags=%03b expected 000", i,
                             {is_call, is_exit, illegal});
                end
            end
        end

        // R9: taken then not-taken back to back with a new pc
        drive(VEC[0]);
        @(negedge clk);
        expect_out("R8 b2b", 1'b1, 32'd106, 3'b000);
        pc = 32'd7; jcode = 4'h5;
        @(negedge clk);
        expect_out("R9 b2b", 1'b0, 32'd8, 3'b000);

        // R1: reset in the middle of traffic clears outputs
        drive(VEC[18]);
        rst = 1'b1;
        @(negedge clk);
        expect_out("R1 midrun", 1'b0, 32'd0, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R8 after reset", 1'b1, 32'd99, 3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule